// File: doc/BRIEF.md
# ADC Burst Oversampling and Averaging Filter

This block sits after an analog-to-digital converter. It receives a stream of 12-bit conversion results, and each result carries a 4-bit channel tag. One channel is selected for filtering. Samples from that channel are summed in bursts, and every completed burst yields one 16-bit filtered result. Samples from any other channel, and every sample while filtering is off, are forwarded unchanged on a separate pass-through output.

Two filter modes exist, and a 3-bit ratio code sets the burst length.

- **Oversampling** extends the resolution. Some codes give integer results of 13 to 16 bits. Other codes give results with one fractional bit.
- **Averaging** forms a true power-of-two mean. The mean can be emitted as a 12-bit integer or as a 12.4 fixed-point value. In fixed-point form, the low nibble can be masked off.

A small control word holds the enable, channel, mode, ratio and 16-bit-data flags. While the peripheral is running, writes to this word are refused and answered with an error pulse. The fractional-output choice for the filtered channel arrives as a separate input.

Top module: `adc_burst_filter`

## Requirements
- R1: After synchronous reset the control word reads 0 and `flt_valid`, `pass_valid` and `cfg_wr_err` are all 0.
- R2: A write with `periph_on`=0 loads `cfg_wr_data` and is visible on `cfg_rdata` one cycle later.
  - A write with `periph_on`=1 leaves `cfg_rdata` unchanged and pulses `cfg_wr_err` high for exactly the following cycle.
  - Control word layout: bit 0 enable, bits 4:1 channel, bits 7:5 ratio code, bit 8 mode (0 oversampling, 1 averaging), bit 9 full-16-bit flag.
- R3: While enabled, only samples whose tag equals the channel field are accumulated.
  - Every other valid sample appears one cycle later on `pass_valid`/`pass_chan`/`pass_data` with its tag and data unchanged.
  - Such samples do not alter the burst in progress.
  - A sample that is accumulated is not passed through.
- R4: While the enable bit is 0, no filtered result is produced and every valid sample is passed through.
- R5: In oversampling mode, ratio codes 0 to 3 sum 4, 16, 64 or 256 samples. The result is the sum shifted right by 1, 2, 3 or 4 bits, right-aligned in 16 bits.
- R6: In oversampling mode, ratio codes 4 to 7 sum 2, 8, 32 or 128 samples. The result is the sum shifted right by 0, 1, 2 or 3 bits, keeping one fractional LSB, right-aligned in 16 bits.
- R7: In averaging mode, code c sums 2^(c+1) samples. With `frac_sel`=0 the result is the sum shifted right by c+1, as a 12-bit value zero-extended to 16 bits.
- R8: In averaging mode with `frac_sel`=1 and the full-16-bit flag set, the result is (sum·16) shifted right by c+1, which is the mean in 12.4 format.
- R9: In averaging mode with `frac_sel`=1 and the full-16-bit flag clear, the R8 result is emitted with its low 4 bits forced to 0.
- R10: The full-16-bit flag has no effect in oversampling mode, and none in averaging mode with `frac_sel`=0.
- R11: Each burst produces a one-cycle `flt_valid` pulse. The pulse comes in the cycle after the burst's last sample is presented. The next burst begins with the next matching sample, so back-to-back samples are all used.
- R12: An accepted control-word write discards any partially accumulated burst, and so does the enable bit being 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_on | input | 1 | Peripheral running; locks the control word |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 10 | Control word write value |
| cfg_rdata | output | 10 | Current control word |
| cfg_wr_err | output | 1 | Error pulse for a refused write |
| frac_sel | input | 1 | Fractional output chosen for the filtered channel |
| smp_valid | input | 1 | Conversion result valid |
| smp_chan | input | 4 | Channel tag of the result |
| smp_data | input | 12 | Conversion result |
| flt_valid | output | 1 | Filtered result valid (one cycle) |
| flt_data | output | 16 | Filtered result |
| pass_valid | output | 1 | Unfiltered sample valid |
| pass_chan | output | 4 | Tag of the unfiltered sample |
| pass_data | output | 12 | Unfiltered sample data |

## Verification
- **Ratio decoding.** The bench sweeps every ratio code in both modes. Alternating sample values make a wrong shift count or a wrong burst length show up as an off-by-a-factor result, or as a pulse at the wrong time.
- **Full-scale bursts.** Bursts of 256 full-scale samples are used. An accumulator that is too narrow would wrap and return a small value.
- **Fixed-point output.** Fractional averaging is run with the 16-bit flag both set and clear. A design that ignores the mask, or applies it outside that mode, returns a nibble that differs from the expected one.
- **Foreign and back-to-back samples.** Off-channel samples are injected mid-burst; letting them leak in would shift the sum. Back-to-back two-sample bursts expose any dead cycle between bursts.
- **Clearing partial state.** Rewrites, and disabling the filter mid-burst, check that leftover partial sums are discarded rather than merged into the next burst.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

    localparam int SMP_W  = 12;             // conversion result width
    localparam int CHAN_W = 4;              // channel tag width
    localparam int CODE_W = 3;              // ratio code width
    localparam int CNT_W  = 8;              // log2 of the largest burst
    localparam int OUT_W  = 16;             // filtered result width
    localparam int FRAC_W = 4;              // fractional bits in averaging mode
    localparam int ACC_W  = SMP_W + CNT_W;  // accumulator width, no overflow
    localparam int LOG_W  = 4;              // width of shift and log2 fields

    typedef enum logic {
        MODE_OVS = 1'b0,
        MODE_AVG = 1'b1
    } fmode_e;

    typedef struct packed {
        logic              full16;
        fmode_e            mode;
        logic [CODE_W-1:0] ratio;
        logic [CHAN_W-1:0] chan;
        logic              en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        logic [LOG_W-1:0] log2n;   // burst length is 2**log2n
        logic [LOG_W-1:0] shamt;   // right shift applied to the sum
    } burst_t;

    function automatic burst_t decode_ratio(fmode_e m, logic [CODE_W-1:0] c);
        burst_t b;
        if (m == MODE_AVG) begin
            b.log2n = {1'b0, c} + 4'd1;
            b.shamt = {1'b0, c} + 4'd1;
        end else if (!c[2]) begin
            b.shamt = {2'b00, c[1:0]} + 4'd1;
            b.log2n = {b.shamt[2:0], 1'b0};
        end else begin
            b.shamt = {2'b00, c[1:0]};
            b.log2n = {1'b0, c[1:0], 1'b1};
        end
        return b;
    endfunction

endpackage

// File: rtl/adcf_cfg_reg.sv
module adcf_cfg_reg
    import adcf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lock,
    input  logic wr_en,
    input  cfg_t wr_data,
    output cfg_t cfg_q,
    output logic wr_err,
    output logic wr_ok
);

    assign wr_ok = wr_en && !lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            wr_err <= 1'b0;
        end else begin
            if (wr_ok) begin
                cfg_q <= wr_data;
            end
            wr_err <= wr_en && lock;
        end
    end

    p_locked_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lock) |=> $stable(cfg_q));

    p_err_cause_r2: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_en && lock));

endmodule

// File: rtl/adcf_accum.sv
module adcf_accum
    import adcf_pkg::*;
#(
    parameter int D_W = SMP_W,
    parameter int C_W = CNT_W,
    parameter int A_W = ACC_W,
    parameter int L_W = LOG_W
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           en,
    input  logic           hit,
    input  logic [D_W-1:0] data,
    input  logic [L_W-1:0] log2n,
    output logic           done,
    output logic [A_W-1:0] total
);

    localparam logic [A_W-1:0] SMP_MAX = A_W'((1 << D_W) - 1);

    logic [A_W-1:0] acc;
    logic [C_W-1:0] cnt;
    logic [C_W:0]   cnt_nx;
    logic           last;

    assign cnt_nx = {1'b0, cnt} + (C_W+1)'(1);
    assign last   = (cnt_nx == ((C_W+1)'(1) << log2n));
    assign total  = acc + A_W'(data);
    assign done   = en && hit && !clr && last;

    always_ff @(posedge clk) begin
        if (rst || clr || !en) begin
            acc <= '0;
            cnt <= '0;
        end else if (hit) begin
            if (last) begin
                acc <= '0;
                cnt <= '0;
            end else begin
                acc <= total;
                cnt <= cnt_nx[C_W-1:0];
            end
        end
    end

    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt} < ((C_W+1)'(1) << log2n)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (acc <= A_W'(cnt) * SMP_MAX));

    p_idle_empty_r12: assert property (@(posedge clk) disable iff (rst)
        (!en || clr) |=> (acc == '0 && cnt == '0));

endmodule

// File: rtl/adcf_format.sv
module adcf_format
    import adcf_pkg::*;
#(
    parameter int A_W = ACC_W,
    parameter int O_W = OUT_W,
    parameter int D_W = SMP_W,
    parameter int F_W = FRAC_W,
    parameter int L_W = LOG_W
)(
    input  logic [A_W-1:0] total,
    input  fmode_e         mode,
    input  logic           frac,
    input  logic           full16,
    input  logic [L_W-1:0] shamt,
    output logic [O_W-1:0] result
);

    always_comb begin
        if (mode == MODE_OVS) begin
            result = O_W'(total >> shamt);
        end else if (!frac) begin
            result = O_W'(D_W'(total >> shamt));
        end else begin
            result = O_W'({total, {F_W{1'b0}}} >> shamt);
            if (!full16) begin
                result[F_W-1:0] = '0;
            end
        end
    end

endmodule

// File: rtl/adc_burst_filter.sv
module adc_burst_filter
    import adcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              periph_on,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic              cfg_wr_err,
    input  logic              frac_sel,
    input  logic              smp_valid,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [SMP_W-1:0]  smp_data,
    output logic              flt_valid,
    output logic [OUT_W-1:0]  flt_data,
    output logic              pass_valid,
    output logic [CHAN_W-1:0] pass_chan,
    output logic [SMP_W-1:0]  pass_data
);

    cfg_t           cfg;
    logic           cfg_ok;
    burst_t         bdec;
    logic           hit;
    logic           done;
    logic [ACC_W-1:0] total;
    logic [OUT_W-1:0] fmt;

    adcf_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .lock    (periph_on),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_t'(cfg_wr_data)),
        .cfg_q   (cfg),
        .wr_err  (cfg_wr_err),
        .wr_ok   (cfg_ok)
    );

    assign cfg_rdata = cfg;
    assign bdec      = decode_ratio(cfg.mode, cfg.ratio);
    assign hit       = smp_valid && (smp_chan == cfg.chan);

    adcf_accum u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (cfg_ok),
        .en    (cfg.en),
        .hit   (hit),
        .data  (smp_data),
        .log2n (bdec.log2n),
        .done  (done),
        .total (total)
    );

    adcf_format u_fmt (
        .total  (total),
        .mode   (cfg.mode),
        .frac   (frac_sel),
        .full16 (cfg.full16),
        .shamt  (bdec.shamt),
        .result (fmt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_valid  <= 1'b0;
            flt_data   <= '0;
            pass_valid <= 1'b0;
            pass_chan  <= '0;
            pass_data  <= '0;
        end else begin
            flt_valid  <= done;
            if (done) begin
                flt_data <= fmt;
            end
            pass_valid <= smp_valid && !(cfg.en && hit);
            if (smp_valid) begin
                pass_chan <= smp_chan;
                pass_data <= smp_data;
            end
        end
    end

    p_off_silent_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> !flt_valid);

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        flt_valid |=> !flt_valid);

    p_one_path_r3: assert property (@(posedge clk) disable iff (rst)
        !(flt_valid && pass_valid));

    p_int_narrow_r7: assert property (@(posedge clk) disable iff (rst)
        (done && cfg.mode == MODE_AVG && !frac_sel) |=> (flt_data[OUT_W-1:SMP_W] == '0));

    p_nibble_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (done && cfg.mode == MODE_AVG && frac_sel && !cfg.full16) |=> (flt_data[FRAC_W-1:0] == '0));

endmodule

// File: tb/test_adc_burst_filter.sv
module test_adc_burst_filter;

    logic        clk = 1'b0;
    logic        rst;
    logic        periph_on;
    logic        cfg_wr_en;
    logic [9:0]  cfg_wr_data;
    logic [9:0]  cfg_rdata;
    logic        cfg_wr_err;
    logic        frac_sel;
    logic        smp_valid;
    logic [3:0]  smp_chan;
    logic [11:0] smp_data;
    logic        flt_valid;
    logic [15:0] flt_data;
    logic        pass_valid;
    logic [3:0]  pass_chan;
    logic [11:0] pass_data;

    int tests = 0;
    int fails = 0;
    int flt_cnt = 0;
    int pass_cnt = 0;

    always #5 clk = ~clk;

    adc_burst_filter i_adc_burst_filter (
        .clk(clk), .rst(rst), .periph_on(periph_on),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rdata(cfg_rdata), .cfg_wr_err(cfg_wr_err),
        .frac_sel(frac_sel), .smp_valid(smp_valid),
        .smp_chan(smp_chan), .smp_data(smp_data),
        .flt_valid(flt_valid), .flt_data(flt_data),
        .pass_valid(pass_valid), .pass_chan(pass_chan),
        .pass_data(pass_data)
    );

    // vector: mode, ratio, frac, full16, sample a, sample b, expected
    localparam int NV = 19;
    localparam logic [45:0] VEC [NV] = '{
        {1'b0, 3'd0, 1'b0, 1'b0, 12'd100,  12'd201,  16'd301},
        {1'b0, 3'd1, 1'b0, 1'b0, 12'd4095, 12'd4095, 16'd16380},
        {1'b0, 3'd2, 1'b0, 1'b0, 12'd1,    12'd2,    16'd12},
        {1'b0, 3'd3, 1'b0, 1'b0, 12'd4095, 12'd4095, 16'd65520},
        {1'b0, 3'd4, 1'b0, 1'b0, 12'd7,    12'd8,    16'd15},
        {1'b0, 3'd5, 1'b0, 1'b0, 12'd10,   12'd13,   16'd46},
        {1'b0, 3'd6, 1'b0, 1'b0, 12'd1000, 12'd1001, 16'd8004},
        {1'b0, 3'd7, 1'b0, 1'b0, 12'd3,    12'd4,    16'd56},
        {1'b1, 3'd0, 1'b0, 1'b0, 12'd5,    12'd8,    16'd6},
        {1'b1, 3'd2, 1'b0, 1'b0, 12'd100,  12'd107,  16'd103},
        {1'b1, 3'd7, 1'b0, 1'b0, 12'd4095, 12'd4095, 16'd4095},
        {1'b1, 3'd0, 1'b1, 1'b1, 12'd5,    12'd8,    16'd104},
        {1'b1, 3'd1, 1'b1, 1'b1, 12'd1,    12'd2,    16'd24},
        {1'b1, 3'd4, 1'b1, 1'b1, 12'd10,   12'd11,   16'd168},
        {1'b1, 3'd4, 1'b1, 1'b0, 12'd10,   12'd11,   16'd160},
        {1'b1, 3'd6, 1'b1, 1'b1, 12'd2,    12'd3,    16'd40},
        {1'b1, 3'd6, 1'b1, 1'b0, 12'd2,    12'd3,    16'd32},
        {1'b0, 3'd0, 1'b1, 1'b0, 12'd100,  12'd201,  16'd301},
        {1'b1, 3'd2, 1'b0, 1'b1, 12'd100,  12'd107,  16'd103}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] mk(input logic en, input logic [3:0] ch,
                                      input logic mode, input logic [2:0] r,
                                      input logic f16);
        return {f16, mode, r, ch, en};
    endfunction

    function automatic int nsmp(input logic mode, input logic [2:0] r);
        if (mode) return 2 << r;
        if (!r[2]) return 1 << (2 * (int'(r) + 1));
        return 2 << (2 * (int'(r) - 4));
    endfunction

    function automatic string vtag(input int i, input logic mode, input logic [2:0] r,
                                   input logic fr, input logic f16);
        if (i >= 17) return "R10";
        if (!mode) return r[2] ? "R6" : "R5";
        if (!fr) return "R7";
        return f16 ? "R8" : "R9";
    endfunction

    task automatic wr_cfg(input logic [9:0] d);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic send(input logic [3:0] ch, input logic [11:0] d);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_chan  = ch;
        smp_data  = d;
    endtask

    task automatic idle();
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (flt_valid) flt_cnt++;
            if (pass_valid) pass_cnt++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R11 actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int f0;
        int p0;
        rst = 1'b1; periph_on = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
        frac_sel = 1'b0; smp_valid = 1'b0; smp_chan = '0; smp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cfg_rdata", 32'(cfg_rdata), 0);
        chk("R1 flt_valid", 32'(flt_valid), 0);
        chk("R1 pass_valid", 32'(pass_valid), 0);
        chk("R1 cfg_wr_err", 32'(cfg_wr_err), 0);

        // R2: locked write refused, unlocked write applied
        periph_on = 1'b1;
        wr_cfg(mk(1'b1, 4'd5, 1'b1, 3'd2, 1'b1));
        chk("R2 locked err", 32'(cfg_wr_err), 1);
        chk("R2 locked rdata", 32'(cfg_rdata), 0);
        idle();
        chk("R2 err one cycle", 32'(cfg_wr_err), 0);
        periph_on = 1'b0;
        wr_cfg(mk(1'b1, 4'd3, 1'b0, 3'd4, 1'b0));
        chk("R2 write rdata", 32'(cfg_rdata), 32'(mk(1'b1, 4'd3, 1'b0, 3'd4, 1'b0)));
        chk("R2 no err", 32'(cfg_wr_err), 0);

        // R3: foreign channel passes through, matching does not
        send(4'd9, 12'h5A5);
        idle();
        chk("R3 pass_valid", 32'(pass_valid), 1);
        chk("R3 pass_chan", 32'(pass_chan), 9);
        chk("R3 pass_data", 32'(pass_data), 32'h5A5);
        chk("R3 no flt", 32'(flt_valid), 0);
        send(4'd3, 12'd77);
        idle();
        chk("R3 matched not passed", 32'(pass_valid), 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic        md;
            logic [2:0]  rc;
            logic        fr;
            logic        f16;
            logic [11:0] va;
            logic [11:0] vb;
            logic [15:0] ex;
            logic [3:0]  sel;
            int          n;
            int          inj;
            string       tg;
            {md, rc, fr, f16, va, vb, ex} = VEC[i];
            sel = 4'(i);
            n   = nsmp(md, rc);
            tg  = vtag(i, md, rc, fr, f16);
            inj = 0;
            wr_cfg(mk(1'b1, sel, md, rc, f16));
            frac_sel = fr;
            #1;
            f0 = flt_cnt;
            p0 = pass_cnt;
            for (int j = 0; j < n; j++) begin
                send(sel, (j % 2 == 1) ? vb : va);
                if (j % 4 == 3 && j != n - 1) begin
                    send(sel ^ 4'd1, 12'd4095);
                    inj++;
                end
            end
            idle();
            #1;
            chk({tg, " result"}, 32'(flt_data), 32'(ex));
            chk("R11 valid after last", 32'(flt_valid), 1);
            chk("R11 one pulse per burst", 32'(flt_cnt - f0), 1);
            chk("R3 foreign passed", 32'(pass_cnt - p0), 32'(inj));
            idle();
            chk("R11 pulse width", 32'(flt_valid), 0);
        end
        frac_sel = 1'b0;

        // R11: back-to-back two-sample bursts
        wr_cfg(mk(1'b1, 4'd2, 1'b0, 3'd4, 1'b0));
        send(4'd2, 12'd1);
        send(4'd2, 12'd2);
        send(4'd2, 12'd3);
        chk("R11 b2b first valid", 32'(flt_valid), 1);
        chk("R11 b2b first data", 32'(flt_data), 3);
        send(4'd2, 12'd4);
        chk("R11 b2b gap", 32'(flt_valid), 0);
        send(4'd2, 12'd5);
        chk("R11 b2b second data", 32'(flt_data), 7);
        send(4'd2, 12'd6);
        idle();
        chk("R11 b2b third valid", 32'(flt_valid), 1);
        chk("R11 b2b third data", 32'(flt_data), 11);

        // R12: rewrite discards partial burst
        wr_cfg(mk(1'b1, 4'd3, 1'b1, 3'd1, 1'b0));
        send(4'd3, 12'd4000);
        send(4'd3, 12'd4000);
        idle();
        wr_cfg(mk(1'b1, 4'd3, 1'b1, 3'd1, 1'b0));
        #1;
        f0 = flt_cnt;
        for (int j = 0; j < 4; j++) send(4'd3, 12'd8);
        idle();
        #1;
        chk("R12 rewrite clears", 32'(flt_data), 8);
        chk("R12 one pulse", 32'(flt_cnt - f0), 1);

        // R4 and R12: disabled filter passes all and drops partial sum
        send(4'd3, 12'd4000);
        send(4'd3, 12'd4000);
        idle();
        wr_cfg(mk(1'b0, 4'd3, 1'b1, 3'd1, 1'b0));
        #1;
        f0 = flt_cnt;
        p0 = pass_cnt;
        for (int j = 0; j < 4; j++) send(4'd3, 12'd100);
        idle();
        idle();
        #1;
        chk("R4 no result when off", 32'(flt_cnt - f0), 0);
        chk("R4 all passed when off", 32'(pass_cnt - p0), 4);
        wr_cfg(mk(1'b1, 4'd3, 1'b1, 3'd1, 1'b0));
        for (int j = 0; j < 4; j++) send(4'd3, 12'd20);
        idle();
        chk("R12 fresh after enable", 32'(flt_data), 20);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule